// File: doc/BRIEF.md
# Fourth-Order Bit-Serial Table-Lookup Filter

This block computes a fourth-order filter without any multiplier. Each stored sample sits in a parallel-to-serial register. One bit from every register is read out per cycle, most significant bit first. Those bits together form the address into a table of precomputed partial sums. The table word goes through a registered read stage into a shift-add accumulator. The step that belongs to the sign bit subtracts instead of adding. After one pass over all sample bits, the accumulator holds the dot product of the coefficients and the samples.

A parameter selects one of two forms.

- **Direct (non-recursive) form.** A new sample is loaded in parallel into the entry register. As the bits are consumed, that register shifts out of its top bit into the serial input of the next register, and so on down the chain. A pass over the bits therefore also moves every sample one tap down the delay line.
- **Recursive form.** Four more registers hold the last four outputs. They rotate during the pass and supply four more address bits. After each result, the newest output is pushed in and the older ones move down one place.

Table entries are written through a simple write port before use.

Top module: `da4_filter`

## Requirements
- R1: While `rst_n` is low and after it rises, `out_valid` is 0 and `out_sample` is 0, and all sample and output history registers hold zero.
- R2: A table entry is written at a rising edge where `tbl_we` is 1, at address `tbl_addr` with value `tbl_data`. Later results use the new entry.
- R3: In the direct form, the table address bit i (i = 0..3) is the current bit of sample x[n-i], where bit 0 is the newest sample. Each result is y = floor((sum of table-weighted sample values) / 2^SHIFT), wrapped to DW bits. With a linear table holding coefficient c_i, this equals floor(sum c_i·x[n-i] / 2^SHIFT) mod 2^DW, read as signed.
- R4: In the recursive form, address bits 4..7 carry the bits of the previous outputs y[n-1]..y[n-4], with bit 4 for y[n-1]. Table entries add the feedback coefficients with their sign already applied. The result becomes y[n-1] for the next sample.
- R5: `out_valid` is a one-cycle pulse. It is high in the cycle that follows the (DW+1)-th rising edge after the edge that accepted the sample. It is never high on two consecutive cycles.
- R6: A valid input that arrives while a computation is running is held in a single slot, and a newer one replaces it. The held sample starts at the first edge at which the unit is idle. A sample that is replaced never enters the delay line.
- R7: The most significant bit of every stored value has negative weight. The extreme negative input −2^(DW−1) contributes −2^(DW−1)·c_i.
- R8: `out_sample` changes only at the edge that raises `out_valid`, and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New input sample present |
| in_sample | input | DW | Signed input sample |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | TAW | Table write address (4 bits direct, 8 bits recursive) |
| tbl_data | input | TW | Signed partial-sum entry |
| out_valid | output | 1 | One-cycle result strobe |
| out_sample | output | DW | Signed filter output |

## Verification
The hardest situation to reach from the ports is the hold slot being overwritten while a pass is in flight. The replaced sample must disappear from the delay line, while the survivor starts on the exact edge the unit goes idle. The bench creates this by holding `in_valid` high with a different value on every cycle for many periods, and later by issuing samples with random gaps of 0 to 3 cycles. A behavioural model tracks which sample survives, and the two results are compared on every clock.

The recursive path only shows feedback errors after several outputs have circulated. For that reason the impulse and extreme-value sequences are each followed by a run of zero inputs, so the feedback taps alone drive the output.

// File: rtl/da4_pkg.sv
package da4_pkg;
   typedef enum logic [0:0] {
      FORM_DIRECT    = 1'b0,
      FORM_RECURSIVE = 1'b1
   } da_form_e;

   function automatic int table_addr_bits(input int order, input da_form_e form);
      return (form == FORM_RECURSIVE) ? 2 * order : order;
   endfunction
endpackage

// File: rtl/da4_p2s.sv
module da4_p2s #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         ser_in,
   output logic         ser_out
);
   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= load_val;
      else if (shift) q <= {q[W-2:0], ser_in};
   end

   assign ser_out = q[W-1];
endmodule

// File: rtl/da4_lut.sv
module da4_lut #(
   parameter int AW = 4,
   parameter int TW = 12,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [TW-1:0] wdata,
   input  logic          rd_en,
   input  logic [AW-1:0] raddr,
   output logic [TW-1:0] rdata
);
   logic [TW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // Registered read: holds the partial sum for the accumulator stage
   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= mem[raddr];
   end
endmodule

// File: rtl/da4_accum.sv
module da4_accum #(
   parameter int TW    = 12,
   parameter int DW    = 8,
   parameter int SHIFT = 4,
   localparam int ACC_W = TW + DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          first,
   input  logic [TW-1:0] part,
   output logic [DW-1:0] y_nxt
);
   logic signed [ACC_W-1:0] acc_q, acc_nxt, part_x;

   assign part_x = {{DW{part[TW-1]}}, part};

   // MSB step carries negative weight; later steps double and add
   always_comb begin
      if (first) acc_nxt = -part_x;
      else       acc_nxt = (acc_q <<< 1) + part_x;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  acc_q <= '0;
      else if (en) acc_q <= acc_nxt;
   end

   assign y_nxt = acc_nxt[SHIFT +: DW];
endmodule

// File: rtl/da4_filter.sv
module da4_filter
   import da4_pkg::*;
#(
   parameter int       DW    = 8,
   parameter int       TW    = 12,
   parameter int       SHIFT = 4,
   parameter int       ORDER = 4,
   parameter da_form_e FORM  = FORM_DIRECT,
   localparam int TAW = table_addr_bits(ORDER, FORM),
   localparam int CW  = $clog2(DW + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [DW-1:0]  in_sample,
   input  logic           tbl_we,
   input  logic [TAW-1:0] tbl_addr,
   input  logic [TW-1:0]  tbl_data,
   output logic           out_valid,
   output logic [DW-1:0]  out_sample
);
   localparam logic [CW-1:0] LAST = CW'(DW);

   if (SHIFT > TW) begin : g_bad_shift
      $error("SHIFT must not exceed TW");
   end
   if (DW < 2 || ORDER < 1) begin : g_bad_size
      $error("DW must be at least 2 and ORDER at least 1");
   end

   logic           busy, pend_v, start, shift_en, finish;
   logic           step_v, first_d;
   logic [CW-1:0]  cnt;
   logic [DW-1:0]  pend_q, start_data, y_nxt;
   logic [ORDER-1:0] tap_msb;
   logic [TAW-1:0] lut_raddr;
   logic [TW-1:0]  part;

   assign start      = !busy && (pend_v || in_valid);
   assign start_data = pend_v ? pend_q : in_sample;
   assign shift_en   = busy && (cnt != LAST);
   assign finish     = busy && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt     <= '0;
         pend_v  <= 1'b0;
         pend_q  <= '0;
         step_v  <= 1'b0;
         first_d <= 1'b0;
      end else begin
         step_v  <= shift_en;
         first_d <= shift_en && (cnt == '0);
         if (finish)        busy <= 1'b0;
         else if (start)    busy <= 1'b1;
         if (start)         cnt <= '0;
         else if (shift_en) cnt <= cnt + 1'b1;
         if (in_valid && !(start && !pend_v)) begin
            pend_q <= in_sample;
            pend_v <= 1'b1;
         end else if (start && pend_v) begin
            pend_v <= 1'b0;
         end
      end
   end

   // Sample chain: entry register loads in parallel, the rest fill serially
   for (genvar i = 0; i < ORDER; i++) begin : g_tap
      if (i == 0) begin : g_entry
         da4_p2s #(.W(DW)) u_reg (
            .clk(clk), .rst_n(rst_n), .load(start), .load_val(start_data),
            .shift(shift_en), .ser_in(1'b0), .ser_out(tap_msb[i]));
      end else begin : g_chain
         da4_p2s #(.W(DW)) u_reg (
            .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
            .shift(shift_en), .ser_in(tap_msb[i-1]), .ser_out(tap_msb[i]));
      end
   end

   if (FORM == FORM_RECURSIVE) begin : g_fb
      logic [DW-1:0]    fb_q [ORDER];
      logic [ORDER-1:0] fb_msb;
      for (genvar j = 0; j < ORDER; j++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)        fb_q[j] <= '0;
            else if (finish)   fb_q[j] <= (j == 0) ? y_nxt : fb_q[(j == 0) ? 0 : j-1];
            else if (shift_en) fb_q[j] <= {fb_q[j][DW-2:0], fb_q[j][DW-1]};
         end
         assign fb_msb[j] = fb_q[j][DW-1];
      end
      assign lut_raddr = {fb_msb, tap_msb};
   end else begin : g_nofb
      assign lut_raddr = tap_msb;
   end

   da4_lut #(.AW(TAW), .TW(TW)) u_lut (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_data),
      .rd_en(shift_en), .raddr(lut_raddr), .rdata(part));

   da4_accum #(.TW(TW), .DW(DW), .SHIFT(SHIFT)) u_acc (
      .clk(clk), .rst_n(rst_n), .en(step_v), .first(first_d),
      .part(part), .y_nxt(y_nxt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= finish;
         if (finish) out_sample <= y_nxt;
      end
   end
endmodule

// File: rtl/da4_filter_chk.sv
module da4_filter_chk #(
   parameter int DW = 8,
   localparam int LW = $clog2(DW + 3)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          start,
   input logic          pend_v,
   input logic          out_valid,
   input logic [DW-1:0] out_sample
);
   logic [LW-1:0] since_start;

   always_ff @(posedge clk) begin
      if (!rst_n)                 since_start <= '1;
      else if (start)             since_start <= '0;
      else if (since_start != '1) since_start <= since_start + 1'b1;
   end

   p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (since_start == LW'(DW + 1)));

   p_hold_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !start) |=> pend_v);

   p_out_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_sample));
endmodule

bind da4_filter da4_filter_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .start(start),
   .pend_v(pend_v), .out_valid(out_valid), .out_sample(out_sample));

// File: tb/da4_filter_tb.sv
`timescale 1ns/1ps
module da4_filter_tb;
   import da4_pkg::*;
   localparam int DW = 8, TW = 12, SHIFT = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0, in_valid = 1'b0;
   logic [DW-1:0] sx = '0;
   logic f_we = 1'b0, i_we = 1'b0;
   logic [3:0] f_addr = '0;
   logic [7:0] i_addr = '0;
   logic [TW-1:0] f_data = '0, i_data = '0;
   logic fov, iov;
   logic [DW-1:0] fout, iout;

   da4_filter #(.DW(DW), .TW(TW), .SHIFT(SHIFT), .ORDER(4), .FORM(FORM_RECURSIVE)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(sx),
      .tbl_we(i_we), .tbl_addr(i_addr), .tbl_data(i_data),
      .out_valid(iov), .out_sample(iout));

   da4_filter #(.DW(DW), .TW(TW), .SHIFT(SHIFT), .ORDER(4), .FORM(FORM_DIRECT)) u_fir (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(sx),
      .tbl_we(f_we), .tbl_addr(f_addr), .tbl_data(f_data),
      .out_valid(fov), .out_sample(fout));

   int errors = 0, checks = 0;
   int cf[4] = '{5, -3, 7, 2};
   int ci[4] = '{6, 2, -3, 1};
   int di[4] = '{5, -3, 2, -1};
   string phase = "R3";
   bit checking = 0;

   // Reference model state
   bit m_busy, m_pv, m_ov;
   int m_cnt, m_pend, m_cur;
   int xh[3];
   int yh[4];
   int m_of, m_oi;

   function automatic int sv8(input logic [DW-1:0] v);
      return int'($signed(v));
   endfunction

   function automatic int fold(input int v);
      logic [DW-1:0] b;
      b = DW'(v >>> SHIFT);
      return sv8(b);
   endfunction

   function automatic int tsum_f(input int a);
      int s = 0;
      for (int i = 0; i < 4; i++) if (a[i]) s += cf[i];
      return s;
   endfunction

   function automatic int tsum_i(input int a);
      int s = 0;
      for (int i = 0; i < 4; i++) if (a[i]) s += ci[i];
      for (int j = 0; j < 4; j++) if (a[4+j]) s += di[j];
      return s;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_pv = 0; m_ov = 0; m_cnt = 0; m_pend = 0; m_cur = 0;
         m_of = 0; m_oi = 0;
         for (int k = 0; k < 3; k++) xh[k] = 0;
         for (int k = 0; k < 4; k++) yh[k] = 0;
      end else begin
         bit st;
         int sd, accf, acci;
         st = !m_busy && (m_pv || in_valid);
         sd = m_pv ? m_pend : sv8(sx);
         m_ov = 0;
         if (m_busy) begin
            if (m_cnt == DW) begin
               accf = cf[0]*m_cur + cf[1]*xh[0] + cf[2]*xh[1] + cf[3]*xh[2];
               acci = ci[0]*m_cur + ci[1]*xh[0] + ci[2]*xh[1] + ci[3]*xh[2]
                    + di[0]*yh[0] + di[1]*yh[1] + di[2]*yh[2] + di[3]*yh[3];
               m_of = fold(accf);
               m_oi = fold(acci);
               xh[2] = xh[1]; xh[1] = xh[0]; xh[0] = m_cur;
               yh[3] = yh[2]; yh[2] = yh[1]; yh[1] = yh[0]; yh[0] = m_oi;
               m_ov = 1; m_busy = 0;
            end else m_cnt++;
         end
         if (in_valid && !(st && !m_pv)) begin m_pend = sv8(sx); m_pv = 1; end
         else if (st && m_pv) m_pv = 0;
         if (st) begin m_busy = 1; m_cnt = 0; m_cur = sd; end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
      end
   endtask

   // Compared on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && checking) begin
         chk(fov == m_ov, "R5 direct strobe", int'(fov), int'(m_ov));
         chk(iov == m_ov, "R5 recursive strobe", int'(iov), int'(m_ov));
         chk(sv8(fout) == m_of, m_ov ? {"R3 direct value, phase ", phase} : "R8 direct hold",
             sv8(fout), m_of);
         chk(sv8(iout) == m_oi, m_ov ? {"R4 recursive value, phase ", phase} : "R8 recursive hold",
             sv8(iout), m_oi);
      end
   end

   task automatic load_tables(input bit fir_only);
      for (int a = 0; a < 256; a++) begin
         @(negedge clk);
         i_we = !fir_only; i_addr = a[7:0]; i_data = TW'(tsum_i(a));
         f_we = (a < 16); f_addr = a[3:0]; f_data = TW'(tsum_f(a));
      end
      @(negedge clk);
      i_we = 0; f_we = 0;
   endtask

   task automatic send(input int v, input int gap);
      @(negedge clk);
      in_valid = 1; sx = DW'(v);
      @(negedge clk);
      in_valid = 0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic run();
      // R1: reset state
      repeat (4) @(negedge clk);
      chk(fov == 0 && iov == 0, "R1 strobes in reset", int'(fov) + int'(iov), 0);
      chk(fout == 0 && iout == 0, "R1 outputs in reset", sv8(fout) + sv8(iout), 0);
      @(negedge clk); rst_n = 1;
      @(negedge clk); checking = 1;
      chk(fov == 0 && fout == 0, "R1 direct after reset", sv8(fout), 0);
      chk(iov == 0 && iout == 0, "R1 recursive after reset", sv8(iout), 0);
      load_tables(0);
      // R3/R4: impulse then zeros lets feedback circulate
      phase = "R3";
      send(16, 12);
      for (int k = 0; k < 8; k++) send(0, 11);
      send(32, 4); send(-20, 9);
      // R7: extremes on the sign bit
      phase = "R7";
      send(-128, 10); send(127, 10); send(-1, 10); send(-128, 10);
      for (int k = 0; k < 5; k++) send(0, 10);
      // R6: continuous valid, slot overwritten while busy
      phase = "R6";
      @(negedge clk);
      for (int k = 0; k < 40; k++) begin
         in_valid = 1; sx = DW'($urandom);
         @(negedge clk);
      end
      in_valid = 0;
      repeat (24) @(negedge clk);
      // R2: rewrite the direct table with new coefficients
      phase = "R2";
      cf = '{-6, 3, 1, -4};
      load_tables(1);
      for (int k = 0; k < 20; k++) send(int'($urandom) % 256 - 128, int'($urandom % 13));
      // Random gaps around the busy window
      phase = "R6";
      for (int k = 0; k < 60; k++) send(int'($urandom % 256) - 128, int'($urandom % 4));
      repeat (30) @(negedge clk);
   endtask

   initial begin
      fork
         run();
         begin
            repeat (100000) @(posedge clk);
            errors++; checks++;
            $display("FAIL R5 watchdog: actual=hung expected=done");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule